// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter

This block decides which of four DMA channels gets the next memory transfer, and it takes the system bus from the processor before any transfer starts. When a channel raises its request line, the block raises a hold request toward the processor. The block grants nothing until the processor returns hold acknowledge. It then picks one winner and holds that channel's one-hot acknowledge for a fixed number of clock cycles. Those cycles form one transfer. When the transfer ends, the block either arbitrates again or gives the bus back.

A mode input chooses between two orderings and can change at run time. In fixed order, channel 0 always wins over channel 1, channel 1 over channel 2, and channel 2 over channel 3. In rotating order, the ranking is always a cyclic shift of 0-1-2-3. Each grant made in rotating mode moves the winner to the bottom of the ranking. The rotation pointer is updated only by grants made in rotating mode, so a period in fixed mode leaves it as it was. If the processor withdraws hold acknowledge, the current channel acknowledge drops at once and the sequencer goes back to idle.

Top module: `dma_arb_top`

## Requirements
- R1: With the bus released (hold_req_o low), a nonzero req_i is answered with hold_req_o high one clock later. While no channel requests in idle, hold_req_o stays low.
- R2: With rot_mode_i = 0 (fixed order), the lowest-numbered requesting channel wins. Bit n of req_i and ack_o belongs to channel n.
- R3: With rot_mode_i = 1, the search starts at a pointer and wraps around from channel 3 to channel 0. Each grant moves the pointer to the channel after the winner. After reset the pointer is 0, so the order is 0-1-2-3.
- R4: No acknowledge is given before hold acknowledge. The first ack_o appears one clock after hold_ack_i is seen high with hold_req_o high.
- R5: ack_o has at most one bit set, and that happens only while hold_ack_i and hold_req_o are both high.
- R6: A granted acknowledge stays unchanged for exactly XFER_CYCLES clocks, even if req_i or rot_mode_i change during that time.
- R7: Between two back-to-back transfers, ack_o is zero for exactly one clock and hold_req_o stays high. The next winner is chosen from req_i as sampled in that gap clock.
- R8: If no request is present when a transfer ends, hold_req_o falls in the same clock in which ack_o falls.
- R9: When hold_ack_i goes low during a transfer, ack_o goes to zero in that same clock. On the next clock hold_req_o is low, and the sequencer has returned to idle.
- R10: Grants made in fixed mode leave the rotation pointer unchanged. A later return to rotating mode carries on from the pointer that was stored before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | NCH | Per-channel transfer request |
| rot_mode_i | input | 1 | 1 = rotating order, 0 = fixed order |
| hold_ack_i | input | 1 | Bus granted by the processor |
| hold_req_o | output | 1 | Bus request toward the processor |
| ack_o | output | NCH | One-hot acknowledge to the channel being served |

## Verification
Each result has a known latency. hold_req_o follows a request from idle by one clock. ack_o follows hold acknowledge in the wait state by one clock. A transfer lasts XFER_CYCLES clocks and is followed by a gap of one clock. A withdrawn hold acknowledge clears ack_o in the same clock, through combinational logic, and clears hold_req_o one clock later. The bench drives inputs on falling edges and samples outputs on falling edges, exactly that number of edges later. It samples combinational results a short delay after the drive. For the table of grants, new requests are applied while a transfer is running, so each vector is judged by the next grant, which is decided in the gap clock.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_arb_pick.sv
// Priority picker: searches the request vector starting at index base,
// wrapping around, and returns the first requesting channel.
module dma_arb_pick #(
  parameter  int NCH  = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  req,
  input  logic [CH_W-1:0] base,
  output logic [CH_W-1:0] win
);
  logic [NCH-1:0] rot_req;

  // rot_req[g] is the channel that sits g places below base in rank
  for (genvar g = 0; g < NCH; g++) begin : g_rot
    assign rot_req[g] = req[(int'(base) + g) % NCH];
  end

  always_comb begin
    int first;
    first = 0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (rot_req[k]) first = k;
    end
    win = CH_W'((int'(base) + first) % NCH);
  end
endmodule

// File: rtl/dma_arb_seq.sv
// Bus-ownership sequencer: hold handshake, transfer timing, grant and
// rotation pointer registers.
module dma_arb_seq
  import dma_arb_pkg::*;
#(
  parameter  int NCH         = 4,
  parameter  int XFER_CYCLES = 4,
  localparam int CH_W        = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CNT_W       = $clog2(XFER_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_req,
  input  logic            hold_ack,
  input  logic            rot_mode,
  input  logic [CH_W-1:0] win,
  output logic [CH_W-1:0] ptr,
  output logic            hold_req,
  output logic            xfer,
  output logic [NCH-1:0]  ack
);
  arb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NCH-1:0]   grant_q, grant_d;
  logic [CH_W-1:0]  ptr_q, ptr_d;
  logic             grant_en, ptr_en, last;

  assign last = (int'(cnt_q) == XFER_CYCLES - 1);

  // next-state logic
  always_comb begin
    state_d  = state_q;
    grant_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (any_req) state_d = ST_WAIT;
      ST_WAIT: begin
        if (!any_req) state_d = ST_IDLE;
        else if (hold_ack) begin
          state_d  = ST_XFER;
          grant_en = 1'b1;
        end
      end
      ST_XFER: begin
        if (!hold_ack) state_d = ST_IDLE;
        else if (last) state_d = any_req ? ST_WAIT : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_d   = (state_q == ST_XFER && state_d == ST_XFER) ? cnt_q + CNT_W'(1) : '0;
    grant_d = NCH'(1) << win;
    ptr_en  = grant_en && rot_mode;
    ptr_d   = (int'(win) == NCH - 1) ? '0 : win + CH_W'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      grant_q <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (grant_en) grant_q <= grant_d;
      if (ptr_en)   ptr_q   <= ptr_d;
    end
  end

  assign ptr      = ptr_q;
  assign xfer     = (state_q == ST_XFER);
  assign hold_req = (state_q != ST_IDLE);
  assign ack      = (xfer && hold_ack) ? grant_q : '0;
endmodule

// File: rtl/dma_arb_top.sv
module dma_arb_top #(
  parameter  int NCH         = 4,
  parameter  int XFER_CYCLES = 4,
  localparam int CH_W        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           rot_mode_i,
  input  logic           hold_ack_i,
  output logic           hold_req_o,
  output logic [NCH-1:0] ack_o
);
  logic [CH_W-1:0] ptr_w, base_w, win_w;
  logic            xfer_w;

  // fixed order always searches from channel 0; the pointer is kept
  assign base_w = rot_mode_i ? ptr_w : '0;

  dma_arb_pick #(.NCH(NCH)) u_pick (
    .req  (req_i),
    .base (base_w),
    .win  (win_w)
  );

  dma_arb_seq #(.NCH(NCH), .XFER_CYCLES(XFER_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_req  (|req_i),
    .hold_ack (hold_ack_i),
    .rot_mode (rot_mode_i),
    .win      (win_w),
    .ptr      (ptr_w),
    .hold_req (hold_req_o),
    .xfer     (xfer_w),
    .ack      (ack_o)
  );
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req_i,
  input logic           hold_ack_i,
  input logic           hold_req_o,
  input logic [NCH-1:0] ack_o,
  input logic           xfer
);
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));

  a_r5_ack_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_o) |-> (hold_ack_i && hold_req_o));

  a_r6_stable_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack_o) && (|$past(ack_o))) |-> (ack_o == $past(ack_o)));

  a_r1_hold_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_req_o && (|req_i)) |=> hold_req_o);

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !hold_ack_i) |=> !hold_req_o);

  a_r4_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_req_o) |=> (ack_o == '0));
endmodule

bind dma_arb_top dma_arb_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .hold_ack_i (hold_ack_i),
  .hold_req_o (hold_req_o),
  .ack_o      (ack_o),
  .xfer       (xfer_w)
);

// File: tb/dma_arb_top_tb_top.sv
`timescale 1ns/1ps
module dma_arb_top_tb_top;
  localparam int NCH   = 4;
  localparam int XFERS = 4;
  localparam int NVEC  = 13;

  logic clk, rst_n, rot_mode, hold_ack, hold_req;
  logic [NCH-1:0] req, ack;
  int n_chk, n_fail, cyc;

  // vector: {rot_mode, req[3:0], expected ack[3:0]}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 4'b1111, 4'b0001},  // R2
    {1'b0, 4'b1100, 4'b0100},  // R2
    {1'b0, 4'b1000, 4'b1000},  // R2
    {1'b1, 4'b1111, 4'b0001},  // R3 ptr 0 -> 1
    {1'b1, 4'b1111, 4'b0010},  // R3 ptr -> 2
    {1'b1, 4'b1111, 4'b0100},  // R3 ptr -> 3
    {1'b1, 4'b1111, 4'b1000},  // R3 wrap, ptr -> 0
    {1'b1, 4'b1010, 4'b0010},  // R3 ptr -> 2
    {1'b1, 4'b0011, 4'b0001},  // R3 search 2,3,0: ptr -> 1
    {1'b0, 4'b1110, 4'b0010},  // R10 fixed, ptr stays 1
    {1'b0, 4'b1111, 4'b0001},  // R10 fixed
    {1'b1, 4'b1111, 4'b0010},  // R10 resumes at ptr 1
    {1'b1, 4'b0101, 4'b0100}   // R3 ptr 2
  };

  dma_arb_top #(.NCH(NCH), .XFER_CYCLES(XFERS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rot_mode_i(rot_mode),
    .hold_ack_i(hold_ack), .hold_req_o(hold_req), .ack_o(ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected below 20000", cyc);
      finish_run();
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wait_ack(bit on);
    for (int i = 0; i < 50; i++) begin
      if ((|ack) == on) return;
      @(negedge clk);
    end
    check("wait for ack level", 8'(|ack), 8'(on));
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0; req = '0; rot_mode = 1'b0; hold_ack = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset hold_req", 8'(hold_req), 8'd0);
    check("R5 reset ack", 8'(ack), 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle without request", 8'(hold_req), 8'd0);

    // table walk: each vector is applied during a transfer, judged by the next grant
    req = 4'b0001; hold_ack = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      wait_ack(1'b1);
      rot_mode = VEC[v][8];
      req      = VEC[v][7:4];
      wait_ack(1'b0);
      wait_ack(1'b1);
      check($sformatf("R2/R3/R10 vector %0d grant", v), 8'(ack), 8'(VEC[v][3:0]));
    end

    // R6 and R7: transfer length, stability under changing requests, gap
    rot_mode = 1'b0; req = 4'b1000;
    wait_ack(1'b0);
    wait_ack(1'b1);
    begin
      int len;
      logic [NCH-1:0] first;
      first = ack; len = 0;
      while (|ack) begin
        if (ack !== first) check("R6 grant stable", 8'(ack), 8'(first));
        len++;
        if (len == 2) req = 4'b0001;
        @(negedge clk);
      end
      check("R6 transfer length", 8'(len), 8'(XFERS));
      check("R7 hold kept in gap", 8'(hold_req), 8'd1);
      @(negedge clk);
      check("R7 one-clock gap then next grant", 8'(ack), 8'b0001);
    end

    // R8: no request left when the transfer ends
    req = '0;
    wait_ack(1'b0);
    check("R8 hold drops with ack", 8'(hold_req), 8'd0);

    // R1 and R4: request with no hold acknowledge
    hold_ack = 1'b0; req = 4'b0100;
    @(negedge clk);
    check("R1 hold_req one clock after request", 8'(hold_req), 8'd1);
    repeat (5) @(negedge clk);
    check("R4 no ack without hold_ack", 8'(ack), 8'd0);
    hold_ack = 1'b1;
    #1;
    check("R4 no ack in the acknowledge clock", 8'(ack), 8'd0);
    @(negedge clk);
    check("R4 ack one clock after hold_ack", 8'(ack), 8'b0100);

    // R9: hold acknowledge withdrawn mid-transfer
    @(negedge clk);
    hold_ack = 1'b0;
    #1;
    check("R9 ack drops at once", 8'(ack), 8'd0);
    @(negedge clk);
    check("R9 back to idle", 8'(hold_req), 8'd0);
    @(negedge clk);
    check("R9 ack stays low", 8'(ack), 8'd0);

    // R3: reset restores rotation order 0-1-2-3
    rst_n = 1'b0; req = '0;
    @(negedge clk);
    rst_n = 1'b1; rot_mode = 1'b1; hold_ack = 1'b1; req = 4'b1111;
    wait_ack(1'b1);
    check("R3 first rotating grant after reset", 8'(ack), 8'b0001);
    wait_ack(1'b0);
    wait_ack(1'b1);
    check("R3 second rotating grant", 8'(ack), 8'b0010);

    finish_run();
  end
endmodule